// File: doc/BRIEF.md
# Timestamp-Triggered Pulse Train Generator

This block drives a small set of periodic pulse outputs in step with an external time-of-day counter. The counter is not part of the block. It arrives as a seconds value, a nanoseconds value and a one-cycle tick strobe, and the strobe marks each advance by one fixed increment. All pulse timing inside the block is counted in these ticks.

For each output, software writes an absolute start time, a period and a high time through a simple word-addressed write strobe interface. It then issues a start command in a shared control register. The output stays armed and reports busy until the time-of-day reaches the start time. From that point it produces a continuous pulse train until a stop command returns it to idle.

Register map (word address `addr[5:0]`): `addr[5:2]==0` is the shared control register. `addr[5:2]==1+i` selects output i, and `addr[1:0]` picks start seconds (0), start nanoseconds (1), period-minus-one (2) or high-time-minus-one (3). Control layout: each output i owns byte `[8i+7:8i]`. Bits `[8i+3:8i]` hold a command (2 = start, 5 = stop) and bits `[8i+7:8i+6]` hold the mode (2'b10 = pulse train). Bit 31 is the enable. Read data appears one cycle after the address.

Top module: `ptg_top`

## Requirements
- R1: After reset every output is low, every register reads zero and no output reports busy (bit 31 of the start-nanoseconds register).
- R2: A control write starts output i only if bit 31 is 1, command bits `[8i+3:8i]` equal 2, mode bits `[8i+7:8i+6]` equal 2'b10, the period register is at least 3 and the output is idle. Busy then reads 1 from the next cycle on.
- R3: An armed output goes high in the cycle after the first tick at which `{tod_sec,tod_nsec}` is greater than or equal to `{start seconds, start nanoseconds}`, with seconds compared before nanoseconds. Busy clears on that same edge.
- R4: While running, the output repeats a pattern of period+1 ticks, with period being the value in the period register. It is high for the first width+1 ticks and low for the rest, width being the high-time register. It changes only after tick edges.
- R5: A start command whose period register is below 3 (fewer than 4 increments) is ignored: the output stays low and busy stays 0.
- R6: A write to the start-seconds or start-nanoseconds register while that output is busy changes neither the armed time nor its readback.
- R7: A control write with bit 31 set and command 5 for output i drives that output low in the next cycle and returns it to idle. It does not restart without a new start command.
- R8: When a stop command and the start-time match for the same output fall on the same clock edge, the stop wins: the output stays low and busy clears.
- R9: The command bits of the control register always read as zero. The mode bits and the enable bit read back the last written value.
- R10: A command for one output leaves every other output's running pulse train undisturbed.
- R11: A control write with bit 31 clear, or with a mode other than 2'b10, does not start the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod_tick | input | 1 | One-cycle strobe: time-of-day advances by one increment |
| tod_sec | input | SEC_W | Time-of-day seconds |
| tod_nsec | input | NS_W | Time-of-day nanoseconds |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for addr |
| pulse_out | output | NUM_OUT | Pulse train outputs, one per channel |

## Verification
The two functions that can land on one clock edge are a stop command and an armed output reaching its start time. The bench keeps its own copy of the time-of-day it drives, advances it until it knows the next tick edge satisfies the start-time comparison, and issues the stop write on exactly that edge. It then requires the output to stay low and busy to read zero for many ticks afterwards. A behavioural model built from the requirements also runs beside every other scenario, so a stop during a running train and a command to a neighbouring output are judged edge by edge.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam logic [3:0] CMD_START  = 4'd2;
  localparam logic [3:0] CMD_STOP   = 4'd5;
  localparam logic [1:0] MODE_TRAIN = 2'b10;
  localparam int         FIELD_W    = 8;
  localparam int         EN_BIT     = 31;
  localparam int         MIN_INTV   = 3;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_ARMED = 2'd1,
    CH_RUN   = 2'd2
  } ch_state_e;
endpackage

// File: rtl/ptg_decode.sv
module ptg_decode
  import ptg_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [5:0]                  addr,
  input  logic [31:0]                 wdata,
  output logic [NUM_OUT-1:0]          start_cmd,
  output logic [NUM_OUT-1:0]          stop_cmd,
  output logic [NUM_OUT-1:0][3:0]     ch_we,
  output logic [NUM_OUT-1:0][1:0]     mode_q,
  output logic                        en_q
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr[5:2] == 4'd0);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_field
    logic [3:0] cmd;
    logic [1:0] mode;
    assign cmd  = wdata[FIELD_W*i +: 4];
    assign mode = wdata[FIELD_W*i + FIELD_W - 2 +: 2];
    assign start_cmd[i] = ctrl_wr && wdata[EN_BIT] && (cmd == CMD_START)
                          && (mode == MODE_TRAIN);
    assign stop_cmd[i]  = ctrl_wr && wdata[EN_BIT] && (cmd == CMD_STOP);
    for (genvar r = 0; r < 4; r++) begin : g_we
      assign ch_we[i][r] = wr_en && (addr[5:2] == 4'(i + 1)) && (addr[1:0] == 2'(r));
    end

    always_ff @(posedge clk) begin
      if (rst) mode_q[i] <= '0;
      else if (ctrl_wr) mode_q[i] <= mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else if (ctrl_wr) en_q <= wdata[EN_BIT];
  end
endmodule

// File: rtl/ptg_channel.sv
module ptg_channel
  import ptg_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30,
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tod_tick,
  input  logic [SEC_W-1:0]   tod_sec,
  input  logic [NS_W-1:0]    tod_nsec,
  input  logic [3:0]         we,
  input  logic [31:0]        wdata,
  input  logic               start_cmd,
  input  logic               stop_cmd,
  output logic               pulse_out,
  output logic               busy,
  output logic [3:0][31:0]   rd_words
);
  ch_state_e          state;
  logic [SEC_W-1:0]   tgt_sec;
  logic [NS_W-1:0]    tgt_nsec;
  logic [CNT_W-1:0]   intv;
  logic [CNT_W-1:0]   wid;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W:0]     cnt_nx;
  logic               reached;

  assign busy    = (state == CH_ARMED);
  assign reached = {tod_sec, tod_nsec} >= {tgt_sec, tgt_nsec};
  assign cnt_nx  = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CH_IDLE;
      tgt_sec   <= '0;
      tgt_nsec  <= '0;
      intv      <= '0;
      wid       <= '0;
      cnt       <= '0;
      pulse_out <= 1'b0;
    end else begin
      if (we[0] && !busy) tgt_sec  <= wdata[SEC_W-1:0];
      if (we[1] && !busy) tgt_nsec <= wdata[NS_W-1:0];
      if (we[2]) intv <= wdata[CNT_W-1:0];
      if (we[3]) wid  <= wdata[CNT_W-1:0];
      if (stop_cmd) begin
        state     <= CH_IDLE;
        cnt       <= '0;
        pulse_out <= 1'b0;
      end else begin
        case (state)
          CH_IDLE: begin
            if (start_cmd && (intv >= CNT_W'(MIN_INTV))) state <= CH_ARMED;
          end
          CH_ARMED: begin
            if (tod_tick && reached) begin
              state     <= CH_RUN;
              cnt       <= '0;
              pulse_out <= 1'b1;
            end
          end
          CH_RUN: begin
            if (tod_tick) begin
              if (cnt == intv) begin
                cnt       <= '0;
                pulse_out <= 1'b1;
              end else begin
                cnt       <= cnt_nx[CNT_W-1:0];
                pulse_out <= (cnt_nx <= {1'b0, wid});
              end
            end
          end
          default: state <= CH_IDLE;
        endcase
      end
    end
  end

  assign rd_words[0] = 32'(tgt_sec);
  assign rd_words[1] = {busy, 31'(tgt_nsec)};
  assign rd_words[2] = 32'(intv);
  assign rd_words[3] = 32'(wid);

  // R7
  stop_low_chk: assert property (@(posedge clk) disable iff (rst)
    stop_cmd |=> !pulse_out && !busy);

  // R3
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && !$past(stop_cmd) |-> pulse_out);

  // R5
  short_period_chk: assert property (@(posedge clk) disable iff (rst)
    (state == CH_IDLE) && start_cmd && (intv < CNT_W'(MIN_INTV)) |=> !busy);

  // R6
  target_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(tgt_sec) && $stable(tgt_nsec));

  // R4
  tick_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_out) |-> $past(tod_tick));
endmodule

// File: rtl/ptg_top.sv
module ptg_top
  import ptg_pkg::*;
#(
  parameter int NUM_OUT = 2,
  parameter int SEC_W   = 32,
  parameter int NS_W    = 30,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tod_tick,
  input  logic [SEC_W-1:0]   tod_sec,
  input  logic [NS_W-1:0]    tod_nsec,
  input  logic               wr_en,
  input  logic [5:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NUM_OUT-1:0] pulse_out
);
  logic [NUM_OUT-1:0]           start_cmd;
  logic [NUM_OUT-1:0]           stop_cmd;
  logic [NUM_OUT-1:0][3:0]      ch_we;
  logic [NUM_OUT-1:0][1:0]      mode_q;
  logic                         en_q;
  logic [NUM_OUT-1:0]           busy;
  logic [NUM_OUT-1:0][3:0][31:0] ch_rd;
  logic [31:0]                  rd_nx;

  ptg_decode #(.NUM_OUT(NUM_OUT)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd), .ch_we(ch_we),
    .mode_q(mode_q), .en_q(en_q)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
    ptg_channel #(.SEC_W(SEC_W), .NS_W(NS_W), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .tod_tick(tod_tick), .tod_sec(tod_sec),
      .tod_nsec(tod_nsec), .we(ch_we[i]), .wdata(wdata),
      .start_cmd(start_cmd[i]), .stop_cmd(stop_cmd[i]),
      .pulse_out(pulse_out[i]), .busy(busy[i]), .rd_words(ch_rd[i])
    );
  end

  always_comb begin
    rd_nx = '0;
    if (addr[5:2] == 4'd0) begin
      rd_nx[EN_BIT] = en_q;
      for (int i = 0; i < NUM_OUT; i++)
        rd_nx[FIELD_W*i + FIELD_W - 2 +: 2] = mode_q[i];
    end
    for (int i = 0; i < NUM_OUT; i++)
      if (addr[5:2] == 4'(i + 1)) rd_nx = ch_rd[i][addr[1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nx;
  end

  // R9
  cmd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(addr[5:2] == 4'd0) |-> rdata[3:0] == 4'd0);
endmodule

// File: tb/ptg_top_test.sv
module ptg_top_test;
  localparam int NO = 2;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tod_tick = 1'b0;
  logic [31:0] tod_sec = '0;
  logic [29:0] tod_nsec = '0;
  logic wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NO-1:0] pulse_out;

  always #10 clk = ~clk;

  ptg_top #(.NUM_OUT(NO)) uut (
    .clk(clk), .rst(rst), .tod_tick(tod_tick), .tod_sec(tod_sec),
    .tod_nsec(tod_nsec), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pulse_out(pulse_out)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  int m_st[NO], m_cnt[NO], m_int[NO], m_wid[NO];
  bit m_out[NO], p_start[NO], p_stop[NO];
  longint m_tsec[NO], m_tns[NO];
  int mism[NO];

  function automatic bit ge(int ch);
    return ({tod_sec, tod_nsec} >= {m_tsec[ch][31:0], m_tns[ch][29:0]});
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    for (int c = 0; c < NO; c++) begin
      if (rst) begin
        m_st[c] = 0; m_out[c] = 0; m_cnt[c] = 0;
        m_tsec[c] = 0; m_tns[c] = 0; m_int[c] = 0; m_wid[c] = 0;
      end else if (p_stop[c]) begin
        m_st[c] = 0; m_out[c] = 0; m_cnt[c] = 0;
      end else begin
        if (tod_tick) begin
          if (m_st[c] == 1 && ge(c)) begin
            m_st[c] = 2; m_cnt[c] = 0; m_out[c] = 1;
          end else if (m_st[c] == 2) begin
            if (m_cnt[c] == m_int[c]) begin m_cnt[c] = 0; m_out[c] = 1; end
            else begin m_cnt[c]++; m_out[c] = (m_cnt[c] <= m_wid[c]); end
          end
        end
        if (p_start[c] && m_st[c] == 0 && m_int[c] >= 3) m_st[c] = 1;
      end
      p_start[c] = 0; p_stop[c] = 0;
      if (!rst && pulse_out[c] !== m_out[c]) mism[c]++;
    end
    if (tod_tick) begin
      if (tod_nsec + 10 >= 1000) begin tod_nsec = '0; tod_sec = tod_sec + 1; end
      else tod_nsec = tod_nsec + 10;
    end
    tod_tick = ~tod_tick;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    if (a[5:2] == 0 && d[31]) begin
      for (int c = 0; c < NO; c++) begin
        if (d[8*c +: 4] == 4'd5) p_stop[c] = 1;
        if (d[8*c +: 4] == 4'd2 && d[8*c+6 +: 2] == 2'b10) p_start[c] = 1;
      end
    end else if (a[5:2] >= 1 && a[5:2] <= NO) begin
      int c = int'(a[5:2]) - 1;
      case (a[1:0])
        2'd0: if (m_st[c] != 1) m_tsec[c] = d;
        2'd1: if (m_st[c] != 1) m_tns[c] = d[29:0];
        2'd2: m_int[c] = d;
        default: m_wid[c] = d;
      endcase
    end
    wr_en = 1; addr = a; wdata = d;
    step();
    wr_en = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a;
    step();
    d = rdata;
  endtask

  task automatic run(int n);
    for (int c = 0; c < NO; c++) mism[c] = 0;
    for (int k = 0; k < n; k++) step();
  endtask

  function automatic logic [5:0] ra(int ch, int r);
    return 6'(((ch + 1) << 2) | r);
  endfunction

  task automatic setup(int ch, int off, int iv, int wd);
    longint ns = longint'(tod_nsec) + off;
    longint s = tod_sec;
    while (ns >= 1000) begin ns -= 1000; s++; end
    wr(ra(ch, 0), 32'(s));
    wr(ra(ch, 1), 32'(ns));
    wr(ra(ch, 2), 32'(iv));
    wr(ra(ch, 3), 32'(wd));
  endtask

  function automatic logic [31:0] start_word(int ch);
    return 32'h8000_0000 | (32'h82 << (8 * ch));
  endfunction

  function automatic logic [31:0] stop_word(int ch);
    return 32'h8000_0000 | (32'h05 << (8 * ch));
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk(pulse_out == '0, "R1 outputs low", pulse_out, 0);
    rd(6'd0, d); chk(d == 0, "R1 control zero", d, 0);
    rd(ra(0, 1), d); chk(d == 0, "R1 nsec/busy zero", d, 0);
    rd(ra(1, 2), d); chk(d == 0, "R1 interval zero", d, 0);
  endtask

  task automatic t_basic(int iv, int wd, string tag);
    logic [31:0] d;
    setup(0, 150, iv, wd);
    wr(6'd0, start_word(0));
    rd(ra(0, 1), d); chk(d[31] == 1, {tag, " R2 busy after start"}, d[31], 1);
    run(160);
    chk(mism[0] == 0, {tag, " R3 R4 train waveform"}, mism[0], 0);
    rd(ra(0, 1), d); chk(d[31] == 0, {tag, " R3 busy cleared"}, d[31], 0);
    wr(6'd0, stop_word(0));
    run(4);
    chk(pulse_out[0] == 0 && mism[0] == 0, "R7 stop forces low", pulse_out[0], 0);
    run(60);
    chk(mism[0] == 0 && pulse_out[0] == 0, "R7 no restart", mism[0], 0);
  endtask

  task automatic t_seconds();
    setup(0, 1020, 4, 1);
    wr(6'd0, start_word(0));
    run(250);
    chk(mism[0] == 0, "R3 seconds compare", mism[0], 0);
    wr(6'd0, stop_word(0));
  endtask

  task automatic t_rejects();
    logic [31:0] d;
    setup(0, 40, 2, 0);
    wr(6'd0, start_word(0));
    rd(ra(0, 1), d); chk(d[31] == 0, "R5 short period no busy", d[31], 0);
    run(60); chk(mism[0] == 0 && pulse_out[0] == 0, "R5 short period low", pulse_out[0], 0);
    wr(ra(0, 2), 32'd7);
    wr(6'd0, 32'h0000_0082);
    rd(ra(0, 1), d); chk(d[31] == 0, "R11 enable clear ignored", d[31], 0);
    wr(6'd0, 32'h8000_0042);
    rd(ra(0, 1), d); chk(d[31] == 0, "R11 wrong mode ignored", d[31], 0);
    run(60); chk(mism[0] == 0 && pulse_out[0] == 0, "R11 output stays low", pulse_out[0], 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(6'd0, 32'h8000_8082);
    rd(6'd0, d); chk(d == 32'h8000_8080, "R9 command reads zero", d, 32'h8000_8080);
    wr(6'd0, 32'h8000_0505);
    rd(6'd0, d); chk(d == 32'h8000_0000, "R9 stop readback", d, 32'h8000_0000);
  endtask

  task automatic t_busy_write();
    logic [31:0] d, keep;
    setup(0, 300, 5, 2);
    keep = 32'(m_tns[0]);
    wr(6'd0, start_word(0));
    wr(ra(0, 1), keep ^ 32'd500);
    wr(ra(0, 0), 32'd99);
    rd(ra(0, 1), d); chk(d[29:0] == keep[29:0] && d[31], "R6 nsec kept", d[29:0], keep[29:0]);
    rd(ra(0, 0), d); chk(d != 32'd99, "R6 sec kept", d, m_tsec[0]);
    run(150);
    chk(mism[0] == 0, "R6 starts at armed time", mism[0], 0);
    wr(6'd0, stop_word(0));
  endtask

  task automatic t_independent();
    setup(0, 60, 9, 4);
    setup(1, 100, 5, 2);
    wr(6'd0, start_word(0) | start_word(1));
    run(120);
    chk(mism[0] == 0 && mism[1] == 0, "R10 two trains", mism[0] + mism[1], 0);
    wr(6'd0, stop_word(1));
    run(120);
    chk(mism[0] == 0, "R10 ch0 unaffected by ch1 stop", mism[0], 0);
    chk(mism[1] == 0 && pulse_out[1] == 0, "R10 ch1 stopped", pulse_out[1], 0);
    wr(6'd0, stop_word(0));
  endtask

  task automatic t_collide();
    logic [31:0] d;
    int guard = 0;
    setup(0, 80, 3, 1);
    wr(6'd0, start_word(0));
    while (!(tod_tick && ge(0)) && guard < 1000) begin step(); guard++; end
    wr(6'd0, stop_word(0));
    chk(pulse_out[0] == 0, "R8 stop beats match", pulse_out[0], 0);
    rd(ra(0, 1), d); chk(d[31] == 0, "R8 busy cleared", d[31], 0);
    run(80); chk(pulse_out[0] == 0 && mism[0] == 0, "R8 stays idle", mism[0], 0);
  endtask

  initial begin
    repeat (4) step();
    rst = 0;
    step();
    t_reset();
    t_basic(3, 1, "min period");
    t_basic(9, 4, "half duty");
    t_seconds();
    t_rejects();
    t_readback();
    t_busy_write();
    t_independent();
    t_collide();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule